// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block gathers interrupt requests from a fixed set of sources and decides which one, if any, is handed to the CPU. The sources are a non-maskable pin, an on-chip break source, a host debug-port source, a four-pin encoded-level input, a group of external request lines and a group of on-chip peripheral lines. Each source carries a priority level on a 0..16 scale. Some levels are fixed, one is read from pins, and the rest come from a small bank of priority registers.

Every cycle the block picks the pending source with the highest level. It compares that level with the CPU's current 4-bit interrupt mask. When the request is accepted, it raises a request to the CPU together with a vector number and the mask value the CPU should load. The request is held, unchanged, until the CPU acknowledges it. The pin inputs pass through a plain synchroniser before they take part in arbitration.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset `cpu_req` is 0 and every priority register reads back as 0.
- R2: A request on `nmi_pin` has level 16 and is accepted whatever the mask value is; it is presented with vector 0 and new mask 15.
- R3: The break source (vector 1) and the host debug-port source (vector 2) both have the fixed level 15. They are not accepted when the mask is 15, and they load a new mask of 15 when accepted.
- R4: The encoded input `enc_lvl_pin` requests at the level equal to its 4-bit value, with vector 3; the value 0 means no request.
- R5: Register n of the priority bank, at address n, holds four 4-bit fields. Field k sits in register k/4 at bits [4*(k%4)+3 : 4*(k%4)]. Fields 0..NUM_EXT-1 set the levels of `ext_req` lines 0..NUM_EXT-1, and fields NUM_EXT.. set the levels of `per_req` lines 0... Writes are synchronous, and reads return the stored value.
- R6: A request other than the non-maskable one is accepted only when its level is strictly greater than `cpu_mask`; `cpu_mask_new` is then the accepted level.
- R7: When several sources are pending, the one with the highest level is presented.
- R8: Pending sources with equal levels are ordered by vector number, and the lower vector wins (so break beats host debug port).
- R9: A programmable source whose field is 0 never produces a CPU request, even with a mask of 0.
- R10: While `cpu_req` is 1 and `cpu_ack` is 0, `cpu_req`, `cpu_vec` and `cpu_mask_new` do not change. An edge with `cpu_ack` high clears `cpu_req`, and arbitration resumes on the following edge.
- R11: Vector numbers are 0 for non-maskable, 1 for break, 2 for host debug port, 3 for encoded level, 4+i for `ext_req[i]` and 4+NUM_EXT+j for `per_req[j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable request pin (synchronised) |
| brk_req | input | 1 | On-chip break request, level 15 |
| hdbg_req | input | 1 | Host debug-port request, level 15 |
| enc_lvl_pin | input | 4 | Encoded level pins, 0 = idle (synchronised) |
| ext_req | input | NUM_EXT | External request lines (synchronised) |
| per_req | input | NUM_PER | On-chip peripheral request lines |
| cpu_mask | input | 4 | Current CPU interrupt mask |
| cpu_ack | input | 1 | CPU acknowledge of the presented request |
| cpu_req | output | 1 | Request to the CPU |
| cpu_vec | output | clog2(4+NUM_EXT+NUM_PER) | Vector number of the presented source |
| cpu_mask_new | output | 4 | Mask value for the CPU to load |
| cfg_wr | input | 1 | Priority register write strobe |
| cfg_addr | input | CFG_AW | Priority register address |
| cfg_wdata | input | 16 | Priority register write data |
| cfg_rdata | output | 16 | Priority register read data |

## Verification
The hardest case to reach from the ports is the one where a fixed, a pin-encoded and a programmed source meet at the same or neighbouring levels while the mask sits just below, at, or above the winner. The synchroniser delays some of these sources and not others, so a naive bench would see an intermediate winner latched. The stimulus therefore applies each pattern with the mask held at 15, which blocks everything except the non-maskable source, and waits for the synchroniser to settle. It then drops the mask to the target value. Random levels are drawn from a narrow range so that ties and near-misses against the mask come up often, and directed cases cover the mask-equals-level boundary, level 0 and the break versus host debug-port tie.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W          = 5;
  localparam int MASK_W         = 4;
  localparam int FIELD_W        = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int REG_W          = FIELD_W * FIELDS_PER_REG;

  localparam logic [LVL_W-1:0] NMI_LVL   = 5'd16;
  localparam logic [LVL_W-1:0] DEBUG_LVL = 5'd15;

  localparam int SRC_NMI       = 0;
  localparam int SRC_BRK       = 1;
  localparam int SRC_HDBG      = 2;
  localparam int SRC_ENC       = 3;
  localparam int SRC_FIRST_EXT = 4;

  // The top level can never be masked; all others must beat the mask.
  function automatic logic lvl_accept(input logic [LVL_W-1:0] lvl,
                                      input logic [MASK_W-1:0] mask);
    return (lvl == NMI_LVL) || (lvl > {1'b0, mask});
  endfunction

  // The new mask equals the level, saturated to the 4-bit range.
  function automatic logic [MASK_W-1:0] mask_from_lvl(input logic [LVL_W-1:0] lvl);
    return (lvl >= NMI_LVL) ? {MASK_W{1'b1}} : lvl[MASK_W-1:0];
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage <= '0;
        end else begin
          stage[0] <= d;
          for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int NFIELD = 12,
  parameter int AW     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [AW-1:0]                 addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NFIELD-1:0][FIELD_W-1:0] fields
);
  localparam int NREG = (NFIELD + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

  logic [NREG-1:0][REG_W-1:0] bank;
  logic                       addr_ok;

  assign addr_ok = (int'(addr) < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
    end else if (wr && addr_ok) begin
      bank[addr] <= wdata;
    end
  end

  assign rdata = addr_ok ? bank[addr] : '0;

  for (genvar k = 0; k < NFIELD; k++) begin : g_field
    assign fields[k] = bank[k / FIELDS_PER_REG][(k % FIELDS_PER_REG) * FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int VEC_W = 4
) (
  input  logic [NSRC-1:0]             pend,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  output logic                        win_valid,
  output logic [VEC_W-1:0]            win_idx,
  output logic [LVL_W-1:0]            win_lvl
);
  // Strict comparison while scanning upward keeps the lowest index on ties.
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (lvl[i] > win_lvl)) begin
        win_lvl = lvl[i];
        win_idx = VEC_W'(i);
      end
    end
    win_valid = (win_lvl != '0);
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_EXT     = 4,
  parameter int NUM_PER     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_AW      = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   nmi_pin,
  input  logic                                   brk_req,
  input  logic                                   hdbg_req,
  input  logic [3:0]                             enc_lvl_pin,
  input  logic [NUM_EXT-1:0]                     ext_req,
  input  logic [NUM_PER-1:0]                     per_req,
  input  logic [3:0]                             cpu_mask,
  input  logic                                   cpu_ack,
  output logic                                   cpu_req,
  output logic [$clog2(4+NUM_EXT+NUM_PER)-1:0]   cpu_vec,
  output logic [3:0]                             cpu_mask_new,
  input  logic                                   cfg_wr,
  input  logic [CFG_AW-1:0]                      cfg_addr,
  input  logic [15:0]                            cfg_wdata,
  output logic [15:0]                            cfg_rdata
);
  localparam int NFIELD = NUM_EXT + NUM_PER;
  localparam int NSRC   = SRC_FIRST_EXT + NFIELD;
  localparam int VEC_W  = $clog2(NSRC);
  localparam int SYNC_W = 1 + FIELD_W + NUM_EXT;

  // Synchronised pin group: non-maskable, encoded level, external lines.
  logic [SYNC_W-1:0]   pins_raw, pins_s;
  logic                nmi_s;
  logic [FIELD_W-1:0]  enc_s;
  logic [NUM_EXT-1:0]  ext_s;

  assign pins_raw = {nmi_pin, enc_lvl_pin, ext_req};

  irq_pin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {nmi_s, enc_s, ext_s} = pins_s;

  logic [NFIELD-1:0][FIELD_W-1:0] fields;

  irq_prio_regs #(.NFIELD(NFIELD), .AW(CFG_AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .fields (fields)
  );

  // Level assignment per source index.
  logic [NSRC-1:0]            pend;
  logic [NSRC-1:0][LVL_W-1:0] lvl;

  always_comb begin
    pend = '0;
    lvl  = '0;
    pend[SRC_NMI]  = nmi_s;
    lvl[SRC_NMI]   = NMI_LVL;
    pend[SRC_BRK]  = brk_req;
    lvl[SRC_BRK]   = DEBUG_LVL;
    pend[SRC_HDBG] = hdbg_req;
    lvl[SRC_HDBG]  = DEBUG_LVL;
    pend[SRC_ENC]  = (enc_s != '0);
    lvl[SRC_ENC]   = {1'b0, enc_s};
    for (int i = 0; i < NUM_EXT; i++) begin
      pend[SRC_FIRST_EXT + i] = ext_s[i];
      lvl[SRC_FIRST_EXT + i]  = {1'b0, fields[i]};
    end
    for (int j = 0; j < NUM_PER; j++) begin
      pend[SRC_FIRST_EXT + NUM_EXT + j] = per_req[j];
      lvl[SRC_FIRST_EXT + NUM_EXT + j]  = {1'b0, fields[NUM_EXT + j]};
    end
  end

  logic              win_valid;
  logic [VEC_W-1:0]  win_idx;
  logic [LVL_W-1:0]  win_lvl;
  logic              accept;

  irq_prio_select #(.NSRC(NSRC), .VEC_W(VEC_W)) u_sel (
    .pend      (pend),
    .lvl       (lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign accept = win_valid && lvl_accept(win_lvl, cpu_mask);

  // CPU handshake: latch on accept, hold until acknowledged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req      <= 1'b0;
      cpu_vec      <= '0;
      cpu_mask_new <= '0;
    end else if (cpu_req) begin
      if (cpu_ack) cpu_req <= 1'b0;
    end else if (accept) begin
      cpu_req      <= 1'b1;
      cpu_vec      <= win_idx;
      cpu_mask_new <= mask_from_lvl(win_lvl);
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_ack,
  input logic [VEC_W-1:0] cpu_vec,
  input logic [3:0]       cpu_mask,
  input logic [3:0]       cpu_mask_new,
  input logic             nmi_seen
);
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ack) |=> (cpu_req && $stable(cpu_vec) && $stable(cpu_mask_new)));

  a_r10_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ack) |=> !cpu_req);

  a_r2_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && nmi_seen) |=> (cpu_req && cpu_vec == '0));

  a_r2_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_vec == '0) |-> (cpu_mask_new == 4'hF));

  a_r3_debug_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && (cpu_vec == VEC_W'(1) || cpu_vec == VEC_W'(2))) |-> (cpu_mask_new == 4'hF));

  a_r6_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_req) && cpu_vec != '0) |-> (cpu_mask_new > $past(cpu_mask)));
endmodule

bind irq_level_arbiter irq_arb_checker #(.VEC_W($clog2(4 + NUM_EXT + NUM_PER))) u_arb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_ack      (cpu_ack),
  .cpu_vec      (cpu_vec),
  .cpu_mask     (cpu_mask),
  .cpu_mask_new (cpu_mask_new),
  .nmi_seen     (nmi_s)
);

// File: tb/test_irq_level_arbiter.sv
`timescale 1ns/1ps
module test_irq_level_arbiter;
  localparam int NE = 4;
  localparam int NP = 8;
  localparam int SYNC = 2;
  localparam int NF = NE + NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 0, brk_req = 0, hdbg_req = 0, cpu_ack = 0, cfg_wr = 0;
  logic [3:0] enc_lvl_pin = 0, cpu_mask = 4'hF;
  logic [NE-1:0] ext_req = 0;
  logic [NP-1:0] per_req = 0;
  logic cpu_req;
  logic [3:0] cpu_vec, cpu_mask_new;
  logic [1:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;

  int n_chk = 0, n_fail = 0;
  int fld [NF];
  int exp_vec, exp_mask;
  bit exp_req;

  always #2.5 clk = ~clk;

  irq_level_arbiter #(.NUM_EXT(NE), .NUM_PER(NP), .SYNC_STAGES(SYNC), .CFG_AW(2)) i_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .brk_req(brk_req), .hdbg_req(hdbg_req),
    .enc_lvl_pin(enc_lvl_pin), .ext_req(ext_req), .per_req(per_req), .cpu_mask(cpu_mask),
    .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_mask_new(cpu_mask_new),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int reg_image(input int r);
    int v = 0;
    for (int f = 0; f < 4; f++)
      if (r * 4 + f < NF) v |= (fld[r * 4 + f] & 15) << (4 * f);
    return v;
  endfunction

  task automatic write_reg(input int r);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 2'(r); cfg_wdata = 16'(reg_image(r));
    @(negedge clk);
    cfg_wr = 0;
  endtask

  // Reference: find the top level first, then the first source holding it.
  task automatic predict(input bit n, input bit b, input bit h, input int e,
                         input logic [NE-1:0] x, input logic [NP-1:0] p, input int m);
    int lv [4 + NF];
    bit pd [4 + NF];
    int top = 0;
    lv[0] = 16; pd[0] = n;
    lv[1] = 15; pd[1] = b;
    lv[2] = 15; pd[2] = h;
    lv[3] = e;  pd[3] = (e != 0);
    for (int i = 0; i < NE; i++) begin lv[4+i] = fld[i]; pd[4+i] = x[i]; end
    for (int j = 0; j < NP; j++) begin lv[4+NE+j] = fld[NE+j]; pd[4+NE+j] = p[j]; end
    for (int s = 0; s < 4 + NF; s++) if (pd[s] && lv[s] > top) top = lv[s];
    exp_vec = 0;
    for (int s = 4 + NF - 1; s >= 0; s--) if (pd[s] && lv[s] == top) exp_vec = s;
    exp_req = (top == 16) || (top > 0 && top > m);
    exp_mask = (top == 16) ? 15 : top;
  endtask

  task automatic trial(input bit n, input bit b, input bit h, input int e,
                       input logic [NE-1:0] x, input logic [NP-1:0] p, input int m,
                       input string tag);
    int v0, m0;
    @(negedge clk);
    nmi_pin = n; brk_req = b; hdbg_req = h; enc_lvl_pin = 4'(e);
    ext_req = x; per_req = p; cpu_mask = 4'hF;
    repeat (SYNC + 2) @(negedge clk);
    cpu_mask = 4'(m);
    @(negedge clk);
    predict(n, b, h, e, x, p, m);
    chk(cpu_req == exp_req, {tag, " req"}, int'(cpu_req), int'(exp_req));
    if (exp_req && cpu_req) begin
      chk(int'(cpu_vec) == exp_vec, {tag, " vector"}, int'(cpu_vec), exp_vec);
      chk(int'(cpu_mask_new) == exp_mask, {tag, " new mask"}, int'(cpu_mask_new), exp_mask);
      v0 = int'(cpu_vec); m0 = int'(cpu_mask_new);
      repeat (3) @(negedge clk);
      chk(cpu_req && int'(cpu_vec) == v0 && int'(cpu_mask_new) == m0,
          "R10 hold before ack", int'(cpu_vec), v0);
      cpu_ack = 1;
      @(negedge clk);
      cpu_ack = 0;
      chk(!cpu_req, "R10 drop after ack", int'(cpu_req), 0);
    end
    nmi_pin = 0; brk_req = 0; hdbg_req = 0; enc_lvl_pin = 0;
    ext_req = 0; per_req = 0; cpu_mask = 4'hF;
    for (int k = 0; k < SYNC + 6; k++) begin
      cpu_ack = cpu_req;
      @(negedge clk);
    end
    cpu_ack = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int f = 0; f < NF; f++) fld[f] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!cpu_req, "R1 req after reset", int'(cpu_req), 0);
    for (int r = 0; r < 3; r++) begin
      cfg_addr = 2'(r);
      #1 chk(cfg_rdata == 16'h0, "R1 register reset", int'(cfg_rdata), 0);
    end
    // R5: field layout and readback
    for (int f = 0; f < NF; f++) fld[f] = (f * 7 + 3) % 16;
    for (int r = 0; r < 3; r++) write_reg(r);
    for (int r = 0; r < 3; r++) begin
      cfg_addr = 2'(r);
      #1 chk(int'(cfg_rdata) == reg_image(r), "R5 readback", int'(cfg_rdata), reg_image(r));
    end
    for (int f = 0; f < NF; f++) fld[f] = 4;
    fld[NE + 1] = 9; fld[NE + 3] = 9; fld[NE + 5] = 0; fld[2] = 6; fld[NE + 2] = 12;
    for (int r = 0; r < 3; r++) write_reg(r);

    trial(1, 0, 0, 0, '0, '0, 15, "R2 nmi at mask 15");
    trial(1, 1, 0, 15, '1, '1, 0, "R2 nmi over all");
    trial(0, 1, 0, 0, '0, '0, 15, "R3 break at mask 15");
    trial(0, 1, 0, 0, '0, '0, 14, "R3 break at mask 14");
    trial(0, 0, 1, 0, '0, '0, 0, "R3 host debug");
    trial(0, 1, 1, 0, '0, '0, 3, "R8 break vs host debug");
    trial(0, 0, 0, 9, '0, '0, 8, "R4 encoded 9 mask 8");
    trial(0, 0, 0, 0, '0, '0, 0, "R4 encoded zero idle");
    trial(0, 0, 0, 9, '0, '0, 9, "R6 level equals mask");
    trial(0, 0, 0, 0, '0, 8'b0010_0000, 0, "R9 level zero source");
    trial(0, 0, 0, 0, '0, 8'b0000_1010, 2, "R8 peripheral tie");
    trial(0, 0, 0, 9, 4'b0100, 8'b0000_0100, 2, "R7 highest level");
    trial(0, 0, 0, 0, 4'b0100, '0, 0, "R11 external vector");
    trial(0, 0, 0, 0, '0, 8'b0000_0100, 0, "R11 peripheral vector");
    trial(0, 0, 0, 4, 4'b0001, '0, 1, "R8 encoded vs external tie");

    for (int t = 0; t < 80; t++) begin
      for (int f = 0; f < NF; f++) fld[f] = ($urandom % 4 == 0) ? int'($urandom % 16) : 8 + int'($urandom % 4);
      for (int r = 0; r < 3; r++) write_reg(r);
      trial(($urandom % 12) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
            ($urandom % 2) ? int'($urandom % 16) : 0,
            NE'($urandom & $urandom), NP'($urandom & $urandom),
            int'($urandom % 16), "R7 random mix");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule